// File: doc/BRIEF.md
# Power-Fail Write-Protect Controller

This block is the control core of a battery-backed static memory wrapper. It watches two supply monitors and the host strobes. The first monitor reports a supply below the fail threshold. The second reports a supply below the level at which the battery must take over. Both monitors are asynchronous and are re-timed by two-flop synchronisers inside the block. While the supply is healthy, the block decodes the host chip-enable, write-enable and output-enable strobes. It turns them into an access mode, a data-output drive enable and a write strobe for the array.

When the supply fails with no write in flight, the block locks the array at once. Host strobes are then ignored and the data pins stay undriven. If a write is in flight, the block defers the lock so that the cycle can finish, but only for a bounded number of clocks. When the supply comes back, the lock stays on for a long recovery interval before host accesses are accepted again. If the supply fails again during that interval, the recovery starts over. A sticky flag keeps the battery isolated until the first complete power-up. After that, the supply selector switches to the battery whenever the supply drops below the takeover level.

Top module: `pfwp_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after reset, `wprot` is 1, `dq_oe` is 0, `mem_we` is 0, `sel_batt` is 0 and `batt_linked` is 0.
- R2: After `pfail_async` is seen low while protected, `wprot` stays 1 for REC_CYC cycles beyond the synchroniser and state delay, then falls. It falls exactly at the 3+REC_CYC-th rising edge after the input change.
- R3: While unprotected, `acc_mode` has four codes. 2'b00 means `ce_n`=1, deselected. 2'b01 means `ce_n`=0, `we_n`=1, `oe_n`=1, outputs off. 2'b10 means `ce_n`=0, `we_n`=1, `oe_n`=0, a read. 2'b11 means `ce_n`=0, `we_n`=0, a write, whatever the level of `oe_n`. `dq_oe` is 1 only for the read code and `mem_we` is 1 only for the write code.
- R4: If `pfail_async` rises while no write is in progress, `wprot` becomes 1 at the third rising edge after the change. While `wprot` is 1, `acc_mode` is 2'b00 and `dq_oe` and `mem_we` are 0, whatever the host strobes do.
- R5: A write is in progress while `ce_n` and `we_n` are both low. If one is in progress when the fail is seen, `wprot` stays 0 and `mem_we` stays 1 until the write ends. The write ends when either strobe rises, and `wprot` is 1 at the next rising edge.
- R6: If the deferred write does not end, `wprot` is forced to 1 WPT_CYC cycles after the deferral begins, which is the 3+WPT_CYC-th edge after the fail input change.
- R7: If `pfail_async` reasserts during recovery, the block returns to full protection. The next recovery lasts the full REC_CYC cycles, counted from the later release.
- R8: `sel_batt` is 1 only when `batt_linked` is 1 and the synchronised takeover input is 1. It follows `below_sw_async` at the third rising edge after a change. Before the first completed power-up it stays 0.
- R9: `batt_linked` becomes 1 at the same edge where the first recovery completes. It then stays 1 through later power failures until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| pfail_async | input | 1 | Asynchronous supply-below-fail-threshold flag |
| below_sw_async | input | 1 | Asynchronous supply-below-battery-takeover flag |
| ce_n | input | 1 | Host chip enable, active low |
| we_n | input | 1 | Host write enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| wprot | output | 1 | Array write protection active |
| dq_oe | output | 1 | Drive the data outputs (low means high impedance) |
| mem_we | output | 1 | Write strobe to the array |
| acc_mode | output | 2 | Decoded host access mode (see R3) |
| sel_batt | output | 1 | Supply selector: 1 selects the battery |
| batt_linked | output | 1 | Battery has been connected by a completed power-up |

## Verification
The fail input is tried in three ways: with the host idle, during a write that finishes early, and during a write that never ends. These runs separate immediate locking, deferral that ends on a strobe, and deferral forced by the timeout. Recovery is tried once cleanly and once with a fail pulse in the middle. A recovery counter that is not restarted would unlock too early, and the bench can see that. The takeover input is toggled both before and after the first completed power-up, to show that the selector is gated by the link flag. All four host decodes are applied both while unprotected and while locked.

// File: rtl/pfwp_pkg.sv
package pfwp_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_PROT   = 2'd2,
        ST_RECOV  = 2'd3
    } pfwp_state_e;

    typedef enum logic [1:0] {
        HM_DESEL = 2'b00,
        HM_NODRV = 2'b01,
        HM_READ  = 2'b10,
        HM_WRITE = 2'b11
    } host_mode_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } host_strb_t;

    typedef struct packed {
        logic       drive;
        logic       wr;
        host_mode_e mode;
    } host_ctl_t;

    function automatic logic write_live(host_strb_t s);
        return !s.ce_n && !s.we_n;
    endfunction

    function automatic host_mode_e decode_mode(host_strb_t s);
        if (s.ce_n)      return HM_DESEL;
        else if (!s.we_n) return HM_WRITE;
        else if (!s.oe_n) return HM_READ;
        else              return HM_NODRV;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pfwp_sync.sv
module pfwp_sync #(
    parameter int   W       = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[g] <= {W{RST_VAL}};
            end else begin
                if (g == 0) stage_q[g] <= d_async;
                else        stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/pfwp_seq.sv
module pfwp_seq
    import pfwp_pkg::*;
#(
    parameter int unsigned WPT_CYC = 5000,
    parameter int unsigned REC_CYC = 4000000
) (
    input  logic clk,
    input  logic rst,
    input  logic pf_s,
    input  logic live,
    output logic wprot_o,
    output logic linked_o
);
    localparam int unsigned CNT_W = $clog2(max_u(WPT_CYC, REC_CYC) + 1);
    localparam logic [CNT_W-1:0] WPT_LAST = CNT_W'(WPT_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_CYC - 1);

    pfwp_state_e      state_q, state_n;
    logic [CNT_W-1:0] cnt_q;
    logic             linked_q;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_NORMAL: if (pf_s) state_n = live ? ST_DRAIN : ST_PROT;
            ST_DRAIN:  if (!live || cnt_q == WPT_LAST) state_n = ST_PROT;
            ST_PROT:   if (!pf_s) state_n = ST_RECOV;
            ST_RECOV: begin
                if (pf_s)                   state_n = ST_PROT;
                else if (cnt_q == REC_LAST) state_n = ST_NORMAL;
            end
            default:   state_n = ST_PROT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_PROT;
            cnt_q    <= '0;
            linked_q <= 1'b0;
        end else begin
            state_q <= state_n;
            if (state_n != state_q || state_q == ST_NORMAL || state_q == ST_PROT)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
            if (state_q == ST_RECOV && state_n == ST_NORMAL)
                linked_q <= 1'b1;
        end
    end

    assign wprot_o  = (state_q == ST_PROT) || (state_q == ST_RECOV);
    assign linked_o = linked_q;

    a_r4_lock_when_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_NORMAL && pf_s && !live) |=> wprot_o);

    a_r5_hold_open_in_drain: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_NORMAL && pf_s && live) |=> !wprot_o);

    a_r7_reassert_relocks: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RECOV && pf_s) |=> (state_q == ST_PROT));

    a_r2_unlock_only_from_recov: assert property (@(posedge clk) disable iff (rst)
        $fell(wprot_o) |-> ($past(state_q) == ST_RECOV && !$past(pf_s)));

    a_r9_link_sticky: assert property (@(posedge clk) disable iff (rst)
        linked_o |=> linked_o);

    a_r9_link_on_powerup: assert property (@(posedge clk) disable iff (rst)
        $rose(linked_o) |-> $fell(wprot_o));
endmodule

// File: rtl/pfwp_host.sv
module pfwp_host
    import pfwp_pkg::*;
(
    input  logic       protect,
    input  host_strb_t strb,
    output host_ctl_t  ctl
);
    host_mode_e raw_mode;

    always_comb begin
        raw_mode = decode_mode(strb);
        if (protect) begin
            ctl.mode  = HM_DESEL;
            ctl.drive = 1'b0;
            ctl.wr    = 1'b0;
        end else begin
            ctl.mode  = raw_mode;
            ctl.drive = (raw_mode == HM_READ);
            ctl.wr    = (raw_mode == HM_WRITE);
        end
    end

    always_comb begin
        if (protect) a_r4_inputs_ignored: assert (!ctl.drive && !ctl.wr && ctl.mode == HM_DESEL);
    end
endmodule

// File: rtl/pfwp_supply.sv
module pfwp_supply (
    input  logic clk,
    input  logic rst,
    input  logic sw_s,
    input  logic linked,
    output logic sel_batt_o
);
    logic sel_q;

    always_ff @(posedge clk) begin
        if (rst) sel_q <= 1'b0;
        else     sel_q <= linked & sw_s;
    end

    assign sel_batt_o = sel_q;

    a_r8_isolated_until_linked: assert property (@(posedge clk) disable iff (rst)
        !linked |=> !sel_batt_o);
endmodule

// File: rtl/pfwp_ctrl.sv
module pfwp_ctrl
    import pfwp_pkg::*;
#(
    parameter int unsigned WPT_CYC = 5000,
    parameter int unsigned REC_CYC = 4000000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pfail_async,
    input  logic       below_sw_async,
    input  logic       ce_n,
    input  logic       we_n,
    input  logic       oe_n,
    output logic       wprot,
    output logic       dq_oe,
    output logic       mem_we,
    output logic [1:0] acc_mode,
    output logic       sel_batt,
    output logic       batt_linked
);
    logic [1:0] mon_s;
    logic       pf_s, sw_s;
    logic       prot_w, linked_w;
    host_strb_t strb;
    host_ctl_t  ctl;

    pfwp_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({pfail_async, below_sw_async}),
        .q_sync  (mon_s)
    );
    assign pf_s = mon_s[1];
    assign sw_s = mon_s[0];

    assign strb = '{ce_n: ce_n, we_n: we_n, oe_n: oe_n};

    pfwp_seq #(.WPT_CYC(WPT_CYC), .REC_CYC(REC_CYC)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .pf_s     (pf_s),
        .live     (write_live(strb)),
        .wprot_o  (prot_w),
        .linked_o (linked_w)
    );

    pfwp_host u_host (
        .protect (prot_w),
        .strb    (strb),
        .ctl     (ctl)
    );

    pfwp_supply u_supply (
        .clk        (clk),
        .rst        (rst),
        .sw_s       (sw_s),
        .linked     (linked_w),
        .sel_batt_o (sel_batt)
    );

    assign wprot       = prot_w;
    assign dq_oe       = ctl.drive;
    assign mem_we      = ctl.wr;
    assign acc_mode    = ctl.mode;
    assign batt_linked = linked_w;

    a_r3_drive_write_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dq_oe, mem_we}));

    a_r1_reset_locked: assert property (@(posedge clk)
        rst |=> (wprot && !batt_linked && !sel_batt));

    a_r5_write_blocked_when_locked: assert property (@(posedge clk) disable iff (rst)
        wprot |-> !mem_we);
endmodule

// File: tb/tb_pfwp_ctrl.sv
module tb_pfwp_ctrl;
    localparam int WPT = 20;
    localparam int REC = 50;

    logic clk = 1'b0;
    logic rst, pfail_async, below_sw_async, ce_n, we_n, oe_n;
    logic wprot, dq_oe, mem_we, sel_batt, batt_linked;
    logic [1:0] acc_mode;
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pfwp_ctrl #(.WPT_CYC(WPT), .REC_CYC(REC)) dut (
        .clk(clk), .rst(rst), .pfail_async(pfail_async), .below_sw_async(below_sw_async),
        .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .wprot(wprot), .dq_oe(dq_oe),
        .mem_we(mem_we), .acc_mode(acc_mode), .sel_batt(sel_batt), .batt_linked(batt_linked)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host(input logic c, input logic w, input logic o);
        ce_n = c; we_n = w; oe_n = o;
        #2;
    endtask

    // Release the fail input while locked and time the unlock (R2)
    task automatic power_return(input string tag);
        pfail_async = 1'b0;
        wait_n(REC + 2);
        check({tag, " R2 still locked"}, wprot, 1);
        wait_n(1);
        check({tag, " R2 unlocked"}, wprot, 0);
    endtask

    task automatic t_reset;
        rst = 1'b1; pfail_async = 1'b0; below_sw_async = 1'b0;
        host(1, 1, 1);
        wait_n(4);
        check("R1 wprot", wprot, 1);
        check("R1 dq_oe", dq_oe, 0);
        check("R1 mem_we", mem_we, 0);
        check("R1 sel_batt", sel_batt, 0);
        check("R1 batt_linked", batt_linked, 0);
        rst = 1'b0;
        wait_n(1);
        check("R1 first cycle wprot", wprot, 1);
        check("R1 first cycle linked", batt_linked, 0);
    endtask

    // First power-up: takeover input pulsed while not linked
    task automatic t_first_powerup;
        below_sw_async = 1'b1;
        wait_n(4);
        check("R8 unlinked sel_batt", sel_batt, 0);
        below_sw_async = 1'b0;
        wait_n(REC + 2 - 5);
        check("R2 power-up locked", wprot, 1);
        check("R9 not yet linked", batt_linked, 0);
        wait_n(1);
        check("R2 power-up unlocked", wprot, 0);
        check("R9 linked at unlock", batt_linked, 1);
    endtask

    task automatic t_decode;
        host(1, 0, 0);
        check("R3 deselect mode", acc_mode, 2'b00);
        check("R3 deselect dq_oe", dq_oe, 0);
        host(0, 1, 1);
        check("R3 outputs-off mode", acc_mode, 2'b01);
        check("R3 outputs-off dq_oe", dq_oe, 0);
        host(0, 1, 0);
        check("R3 read mode", acc_mode, 2'b10);
        check("R3 read dq_oe", dq_oe, 1);
        check("R3 read mem_we", mem_we, 0);
        host(0, 0, 0);
        check("R3 write mode", acc_mode, 2'b11);
        check("R3 write mem_we", mem_we, 1);
        check("R3 write dq_oe", dq_oe, 0);
        host(1, 1, 1);
        wait_n(1);
    endtask

    task automatic t_idle_fail;
        pfail_async = 1'b1;
        wait_n(2);
        check("R4 not yet locked", wprot, 0);
        wait_n(1);
        check("R4 locked", wprot, 1);
        host(0, 0, 0);
        check("R4 write ignored mem_we", mem_we, 0);
        check("R4 write ignored mode", acc_mode, 2'b00);
        host(0, 1, 0);
        check("R4 read ignored dq_oe", dq_oe, 0);
        host(1, 1, 1);
        wait_n(1);
    endtask

    task automatic t_drain_done;
        host(0, 0, 1);
        pfail_async = 1'b1;
        wait_n(3);
        check("R5 open while writing", wprot, 0);
        check("R5 write passes", mem_we, 1);
        wait_n(4);
        check("R5 still open", wprot, 0);
        host(0, 1, 1);
        wait_n(1);
        check("R5 locked after write end", wprot, 1);
        host(1, 1, 1);
    endtask

    task automatic t_drain_timeout;
        host(0, 0, 1);
        pfail_async = 1'b1;
        wait_n(2 + WPT);
        check("R6 open before timeout", wprot, 0);
        check("R6 write live before timeout", mem_we, 1);
        wait_n(1);
        check("R6 forced lock", wprot, 1);
        check("R6 write blocked", mem_we, 0);
        host(1, 1, 1);
    endtask

    task automatic t_recov_abort;
        pfail_async = 1'b0;
        wait_n(13);
        pfail_async = 1'b1;
        wait_n(5);
        pfail_async = 1'b0;
        wait_n(35);
        check("R7 no early unlock", wprot, 1);
        wait_n(17);
        check("R7 full recovery locked", wprot, 1);
        wait_n(1);
        check("R7 unlock after restart", wprot, 0);
    endtask

    task automatic t_battery;
        below_sw_async = 1'b1;
        wait_n(2);
        check("R8 sel before sync", sel_batt, 0);
        wait_n(1);
        check("R8 battery selected", sel_batt, 1);
        pfail_async = 1'b1;
        wait_n(5);
        check("R9 link kept in power-down", batt_linked, 1);
        below_sw_async = 1'b0;
        wait_n(3);
        check("R8 back to main", sel_batt, 0);
        check("R9 link kept", batt_linked, 1);
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_first_powerup();
        t_decode();
        t_idle_fail();
        power_return("idle");
        t_drain_done();
        power_return("drain");
        t_drain_timeout();
        power_return("timeout");
        t_idle_fail();
        t_recov_abort();
        t_battery();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule